// File: doc/BRIEF.md
# SDR SDRAM Command Controller

This block sits between a simple host port and a two-bank, 16-bit SDR SDRAM with a multiplexed address bus. After reset it holds the memory deselected for the power-up interval. It then runs the start-up sequence and programs the mode register with the chosen CAS latency. Once that is done it serves one host word per request. Each request opens the row with ACTIVE, waits tRCD and issues READ or WRITE with auto-precharge, so no row stays open between requests. A free-running timer paces one AUTO REFRESH per 15.6 us of clock cycles, which keeps 2048 rows inside a 32 ms budget.

The controller is one state machine with eight states. PWRUP counts the power-up interval and goes to PREALL. PREALL goes through NOP to AREF. AREF goes through NOP to a second AREF during start-up, then to LMR. After start-up, AREF goes to IDLE. LMR goes through NOP to IDLE. From IDLE, a pending refresh goes to AREF, and otherwise a request goes to ACT. ACT goes through NOP to RW, and RW goes through NOP back to IDLE. NOP counts down the spacing that the last command needs, then enters the state stored for it. Read data is sampled from the data input on the clock edge that matches the programmed CAS latency of 2 or 3.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is held, sd_cke is low, sd_cs_n is high, and req_ack and rd_valid are low. After reset releases, the memory sees only deselect or NOP for INIT_CYCLES = CLK_KHZ/5 cycles, which is 200 us.
- R2: Commands are encoded as {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. The first four commands are PRECHARGE with address bit 10 high, AUTO REFRESH, AUTO REFRESH, then LOAD MODE with CAS_LAT in address bits 6:4 and all other address bits zero. No request is acknowledged before this sequence ends.
- R3: Spacing between commands, measured in cycles from one command to the next: PRECHARGE to next is at least T_RP. AUTO REFRESH to next is at least T_RC. LOAD MODE to next is at least T_MRD. ACTIVE to READ/WRITE is exactly T_RCD. READ/WRITE to next is at least T_RP+2. ACTIVE to next ACTIVE is at least T_RC.
- R4: The host address maps as bank = bit 19, row = bits 18:8, column = bits 7:0. ACTIVE carries the bank and the row. READ/WRITE carries the same bank, the column in bits 7:0, bits 9:8 zero, and bit 10 high for auto-precharge. req_ack is high for exactly the one cycle in which that request's ACTIVE is driven.
- R5: A WRITE drives the write data on sd_dq_out with sd_dq_oe high. sd_dqm[i] is the inverse of req_be[i], where lane i is data bits 8i+7:8i, so a lane whose enable is low leaves that byte unchanged in memory. sd_dq_oe is low for every other command.
- R6: Read data is sampled from sd_dq_in on the CAS_LAT-th rising edge after the edge that registers READ. rd_valid then pulses for one cycle with that word on rd_data, CAS_LAT+1 cycles after the READ cycle. This holds for CAS_LAT 2 and 3.
- R7: After start-up, the gap between two periodic AUTO REFRESH commands never exceeds REF_CYCLES+16 cycles, where REF_CYCLES = CLK_KHZ*156/10000.
- R8: When a refresh is pending and the controller is idle, AUTO REFRESH is issued before any further ACTIVE, even while requests arrive back to back.
- R9: sd_cke is high in the cycle before any command other than NOP or deselect, and it stays high after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, held until acknowledged |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address {bank,row,column} |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for the write |
| req_ack | output | 1 | Request accepted (one cycle) |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | Clock enable to memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | 11 | Multiplexed row/column address |
| sd_dqm | output | 2 | Byte masks |
| sd_dq_out | output | 16 | Data to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from memory |

## Verification
The hardest situation to reach from the ports is a refresh that falls due while the host keeps the request line busy. The controller must then put AUTO REFRESH ahead of the next ACTIVE. The bench issues long runs of back-to-back requests that take many refresh intervals, so that the timer expires in every phase of an access, and it measures each periodic refresh gap. Two instances with CAS latency 2 and 3 run in lockstep against a behavioural memory. That memory drives data only in its latency slot, so capturing one edge early or late returns a wrong word.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;

    typedef enum logic [2:0] {
        S_PWRUP, S_PREALL, S_AREF, S_LMR, S_IDLE, S_ACT, S_RW, S_NOP
    } ctrl_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR   = 4'b0000,
        CMD_AREF  = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_READ  = 4'b0101,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } sd_cmd_t;

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int unsigned INTERVAL = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_done,
    output logic ref_due
);
    localparam int unsigned CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] tick_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            ref_due  <= 1'b0;
        end else begin
            if (ref_done) ref_due <= 1'b0;
            if (!run) begin
                tick_cnt <= '0;
            end else if (tick_cnt == CW'(INTERVAL - 1)) begin
                tick_cnt <= '0;
                ref_due  <= 1'b1;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    AST_DUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_due && !ref_done) |=> ref_due); // R7

endmodule

// File: rtl/sdram_read_capture.sv
module sdram_read_capture #(
    parameter int unsigned CAS_LAT = 3,
    parameter int unsigned DW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_issue,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic [CAS_LAT-1:0] lat_pipe;
    logic               take;

    generate
        if (CAS_LAT == 2) begin : g_cl2
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lat_pipe <= '0;
                else        lat_pipe <= {lat_pipe[0], rd_issue};
            end
        end else begin : g_cl3
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lat_pipe <= '0;
                else        lat_pipe <= {lat_pipe[CAS_LAT-2:0], rd_issue};
            end
        end
    endgenerate

    assign take = lat_pipe[CAS_LAT-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= take;
            if (take) rd_data <= dq_in;
        end
    end

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6
    AST_RD_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_issue, CAS_LAT + 1)); // R6

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
    import sdram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 200000,
    parameter int unsigned CAS_LAT = 3,
    parameter int unsigned T_RCD   = 3,
    parameter int unsigned T_RP    = 3,
    parameter int unsigned T_RC    = 9,
    parameter int unsigned T_MRD   = 2,
    parameter int unsigned ROW_W   = 11,
    parameter int unsigned COL_W   = 8,
    parameter int unsigned DW      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W:0]   req_addr,
    input  logic [DW-1:0]          req_wdata,
    input  logic [DW/8-1:0]        req_be,
    output logic                   req_ack,
    output logic                   rd_valid,
    output logic [DW-1:0]          rd_data,
    output logic                   sd_cke,
    output logic                   sd_cs_n,
    output logic                   sd_ras_n,
    output logic                   sd_cas_n,
    output logic                   sd_we_n,
    output logic                   sd_ba,
    output logic [ROW_W-1:0]       sd_addr,
    output logic [DW/8-1:0]        sd_dqm,
    output logic [DW-1:0]          sd_dq_out,
    output logic                   sd_dq_oe,
    input  logic [DW-1:0]          sd_dq_in
);
    localparam int unsigned AW          = ROW_W + COL_W + 1;
    localparam int unsigned INIT_CYCLES = CLK_KHZ * 200 / 1000;
    localparam int unsigned REF_CYCLES  = CLK_KHZ * 156 / 10000;
    localparam int unsigned GAP_ROW     = T_RC - T_RCD;
    localparam int unsigned GAP_PRE     = T_RP + 2;
    localparam int unsigned GAP_DATA    = CAS_LAT + 2;
    localparam int unsigned GAP_1       = (GAP_ROW > GAP_PRE) ? GAP_ROW : GAP_PRE;
    localparam int unsigned RW_GAP      = (GAP_1 > GAP_DATA) ? GAP_1 : GAP_DATA;
    localparam int unsigned WAIT_MAX    = T_RC + T_RP + T_RCD + T_MRD + RW_GAP;
    localparam int unsigned WCW         = $clog2(WAIT_MAX + 1);
    localparam int unsigned ICW         = $clog2(INIT_CYCLES + 1);

    ctrl_state_t        state, after;
    sd_cmd_t            cmd;
    logic [WCW-1:0]     wait_cnt;
    logic [ICW-1:0]     init_cnt;
    logic               boot_ref, init_done, cke_q;
    logic               lat_we, lat_bank;
    logic [ROW_W-1:0]   lat_row;
    logic [COL_W-1:0]   lat_col;
    logic [DW-1:0]      lat_wdata;
    logic [DW/8-1:0]    lat_be;
    logic               ref_due, ref_done, rd_issue;

    // state register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_PWRUP;
            after     <= S_IDLE;
            wait_cnt  <= '0;
            init_cnt  <= '0;
            boot_ref  <= 1'b0;
            init_done <= 1'b0;
            cke_q     <= 1'b0;
            lat_we    <= 1'b0;
            lat_bank  <= 1'b0;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_wdata <= '0;
            lat_be    <= '0;
        end else begin
            cke_q <= 1'b1;
            unique case (state)
                S_PWRUP: begin
                    if (init_cnt == ICW'(INIT_CYCLES - 1)) state <= S_PREALL;
                    else init_cnt <= init_cnt + 1'b1;
                end
                S_PREALL: begin
                    wait_cnt <= WCW'(T_RP - 1);
                    after    <= S_AREF;
                    boot_ref <= 1'b1;
                    state    <= S_NOP;
                end
                S_AREF: begin
                    wait_cnt <= WCW'(T_RC - 1);
                    state    <= S_NOP;
                    if (init_done) begin
                        after <= S_IDLE;
                    end else if (boot_ref) begin
                        boot_ref <= 1'b0;
                        after    <= S_AREF;
                    end else begin
                        after <= S_LMR;
                    end
                end
                S_LMR: begin
                    wait_cnt  <= WCW'(T_MRD - 1);
                    after     <= S_IDLE;
                    init_done <= 1'b1;
                    state     <= S_NOP;
                end
                S_IDLE: begin
                    if (ref_due) begin
                        state <= S_AREF;
                    end else if (req) begin
                        lat_we    <= req_we;
                        lat_bank  <= req_addr[AW-1];
                        lat_row   <= req_addr[AW-2:COL_W];
                        lat_col   <= req_addr[COL_W-1:0];
                        lat_wdata <= req_wdata;
                        lat_be    <= req_be;
                        state     <= S_ACT;
                    end
                end
                S_ACT: begin
                    wait_cnt <= WCW'(T_RCD - 1);
                    after    <= S_RW;
                    state    <= S_NOP;
                end
                S_RW: begin
                    wait_cnt <= WCW'(RW_GAP - 1);
                    after    <= S_IDLE;
                    state    <= S_NOP;
                end
                S_NOP: begin
                    if (wait_cnt <= WCW'(1)) state <= after;
                    if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
                end
            endcase
        end
    end

    // memory-side outputs decoded from the state
    always_comb begin
        cmd       = CMD_NOP;
        sd_ba     = 1'b0;
        sd_addr   = '0;
        sd_dqm    = '0;
        sd_dq_oe  = 1'b0;
        sd_dq_out = lat_wdata;
        unique case (state)
            S_PWRUP: begin
                cmd    = CMD_DESEL;
                sd_dqm = '1;
            end
            S_PREALL: begin
                cmd              = CMD_PRE;
                sd_addr[ROW_W-1] = 1'b1;
            end
            S_AREF: cmd = CMD_AREF;
            S_LMR: begin
                cmd          = CMD_LMR;
                sd_addr[6:4] = 3'(CAS_LAT);
            end
            S_ACT: begin
                cmd     = CMD_ACT;
                sd_ba   = lat_bank;
                sd_addr = lat_row;
            end
            S_RW: begin
                cmd                  = lat_we ? CMD_WRITE : CMD_READ;
                sd_ba                = lat_bank;
                sd_addr[COL_W-1:0]   = lat_col;
                sd_addr[ROW_W-1]     = 1'b1;
                if (lat_we) begin
                    sd_dqm   = ~lat_be;
                    sd_dq_oe = 1'b1;
                end
            end
            S_IDLE, S_NOP: ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke   = cke_q;
    assign req_ack  = (state == S_ACT);
    assign rd_issue = (state == S_RW) && !lat_we;
    assign ref_done = (state == S_AREF) && init_done;

    sdram_refresh_timer #(.INTERVAL(REF_CYCLES)) u_ref_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (init_done),
        .ref_done (ref_done),
        .ref_due  (ref_due)
    );

    sdram_read_capture #(.CAS_LAT(CAS_LAT), .DW(DW)) u_rd_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (rd_issue),
        .dq_in    (sd_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    AST_CKE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP && cmd != CMD_DESEL) |-> $past(sd_cke)); // R9
    AST_REF_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && ref_due) |=> (state == S_AREF)); // R8
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack); // R4
    AST_NO_ACK_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !req_ack); // R2

endmodule

// File: tb/sdram_cmd_ctrl_tb.sv
`timescale 1ns/1ps

package sdram_tb_pkg;
    function automatic logic [15:0] seed_word(input int a);
        return 16'(a * 40503 + 4660);
    endfunction
endpackage

module sdram_mem_model #(
    parameter int CL = 3
) (
    input  logic        clk,
    input  logic        cs_n,
    input  logic        ras_n,
    input  logic        cas_n,
    input  logic        we_n,
    input  logic        ba,
    input  logic [10:0] addr,
    input  logic [1:0]  dqm,
    input  logic [15:0] dq_out,
    output logic [15:0] dq_in
);
    import sdram_tb_pkg::*;
    logic [15:0] mem [int];
    logic [10:0] open_row [2];
    int          rd_wait = 0;
    logic [15:0] rd_word = 16'h0;

    initial dq_in = 16'hDEAD;

    always @(negedge clk) begin
        logic [3:0] c;
        int key;
        logic [15:0] w;
        c = {cs_n, ras_n, cas_n, we_n};
        dq_in <= 16'hDEAD;
        if (rd_wait == 1) dq_in <= rd_word;
        if (rd_wait > 0) rd_wait = rd_wait - 1;
        if (c == 4'b0011) open_row[ba] = addr;
        if (c == 4'b0101 || c == 4'b0100) begin
            key = int'({ba, open_row[ba], addr[7:0]});
            w = mem.exists(key) ? mem[key] : seed_word(key);
            if (c == 4'b0100) begin
                if (!dqm[0]) w[7:0]  = dq_out[7:0];
                if (!dqm[1]) w[15:8] = dq_out[15:8];
                mem[key] = w;
            end else begin
                rd_word = w;
                rd_wait = CL;
            end
        end
    end
endmodule

module sdram_cmd_ctrl_tb;
    import sdram_tb_pkg::*;

    localparam int CLK_KHZ  = 5000;
    localparam int INIT_CYC = CLK_KHZ * 200 / 1000;
    localparam int REF_CYC  = CLK_KHZ * 156 / 10000;
    localparam int TRCD = 3, TRP = 3, TRC = 9, TMRD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;

    logic ack2, rv2, cke2, cs2, ras2, cas2, we2, ba2, oe2;
    logic [15:0] rd2, dqo2, dqi2;
    logic [10:0] a2;
    logic [1:0]  m2;
    logic ack3, rv3, cke3, cs3, ras3, cas3, we3, ba3, oe3;
    logic [15:0] rd3, dqo3, dqi3;
    logic [10:0] a3;
    logic [1:0]  m3;

    int cyc = 0, n_checks = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_cmd_ctrl #(.CLK_KHZ(CLK_KHZ), .CAS_LAT(2), .T_RCD(TRCD), .T_RP(TRP),
                     .T_RC(TRC), .T_MRD(TMRD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ack(ack2), .rd_valid(rv2),
        .rd_data(rd2), .sd_cke(cke2), .sd_cs_n(cs2), .sd_ras_n(ras2), .sd_cas_n(cas2),
        .sd_we_n(we2), .sd_ba(ba2), .sd_addr(a2), .sd_dqm(m2), .sd_dq_out(dqo2),
        .sd_dq_oe(oe2), .sd_dq_in(dqi2));

    sdram_cmd_ctrl #(.CLK_KHZ(CLK_KHZ), .CAS_LAT(3), .T_RCD(TRCD), .T_RP(TRP),
                     .T_RC(TRC), .T_MRD(TMRD)) u_dut_cl3 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ack(ack3), .rd_valid(rv3),
        .rd_data(rd3), .sd_cke(cke3), .sd_cs_n(cs3), .sd_ras_n(ras3), .sd_cas_n(cas3),
        .sd_we_n(we3), .sd_ba(ba3), .sd_addr(a3), .sd_dqm(m3), .sd_dq_out(dqo3),
        .sd_dq_oe(oe3), .sd_dq_in(dqi3));

    sdram_mem_model #(.CL(2)) u_mem2 (.clk(clk), .cs_n(cs2), .ras_n(ras2), .cas_n(cas2),
        .we_n(we2), .ba(ba2), .addr(a2), .dqm(m2), .dq_out(dqo2), .dq_in(dqi2));
    sdram_mem_model #(.CL(3)) u_mem3 (.clk(clk), .cs_n(cs3), .ras_n(ras3), .cas_n(cas3),
        .we_n(we3), .ba(ba3), .addr(a3), .dqm(m3), .dq_out(dqo3), .dq_in(dqi3));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected-value helpers
    logic [15:0] ref_mem [int];
    function automatic logic [15:0] ref_word(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : seed_word(a);
    endfunction
    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] be);
        return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
    endfunction

    // command monitor on the CL=2 instance
    int rel_cyc = 0, n_cmds = 0, last_cyc = 0, last_act = 0, rd_cmd_cyc = 0;
    int last_pref = 0, n_pref = 0, rw_count = 0;
    bit have_act = 0, prev_cke = 0;
    logic [3:0] last_c = 4'b0111;
    logic cur_we = 0;
    logic [19:0] cur_addr = '0;
    logic [15:0] cur_data = '0;
    logic [1:0]  cur_be = '0;

    always @(negedge clk) begin
        logic [3:0] c;
        int gap;
        c = {cs2, ras2, cas2, we2};
        if (rst_n && !c[3] && c != 4'b0111) begin
            gap = cyc - last_cyc;
            if (n_cmds == 0) begin
                chk(cyc - rel_cyc >= INIT_CYC, "R1 power-up quiet cycles", cyc - rel_cyc, INIT_CYC);
                chk(prev_cke, "R9 cke before first command", prev_cke, 1);
            end
            if (n_cmds == 0) chk(c == 4'b0010 && a2[10], "R2 first PRECHARGE all", {c, a2}, {4'b0010, 11'h400});
            if (n_cmds == 1 || n_cmds == 2) chk(c == 4'b0001, "R2 boot AUTO REFRESH", c, 4'b0001);
            if (n_cmds == 3) begin
                chk(c == 4'b0000, "R2 LOAD MODE command", c, 4'b0000);
                chk(a2 == 11'h020, "R2 mode value CL2", a2, 11'h020);
                chk(a3 == 11'h030, "R2 mode value CL3", a3, 11'h030);
            end
            if (n_cmds > 0) begin
                case (last_c)
                    4'b0010: chk(gap >= TRP, "R3 PRECHARGE spacing", gap, TRP);
                    4'b0001: chk(gap >= TRC, "R3 AUTO REFRESH spacing", gap, TRC);
                    4'b0000: chk(gap >= TMRD, "R3 LOAD MODE spacing", gap, TMRD);
                    4'b0011: chk(gap == TRCD && (c == 4'b0101 || c == 4'b0100),
                                 "R3 ACTIVE to READ/WRITE", gap, TRCD);
                    4'b0101, 4'b0100: chk(gap >= TRP + 2, "R3 READ/WRITE spacing", gap, TRP + 2);
                    default: ;
                endcase
            end
            if (c == 4'b0011) begin
                if (have_act) chk(cyc - last_act >= TRC, "R3 ACTIVE to ACTIVE", cyc - last_act, TRC);
                chk(ba2 == cur_addr[19] && a2 == cur_addr[18:8], "R4 ACTIVE bank/row",
                    {ba2, a2}, cur_addr[19:8]);
                chk(ack2 && ack3, "R4 ack with ACTIVE", {ack2, ack3}, 2'b11);
                last_act = cyc;
                have_act = 1;
            end
            if (c == 4'b0101 || c == 4'b0100) begin
                chk(ba2 == cur_addr[19] && a2 == {3'b100, cur_addr[7:0]}, "R4 column/auto-precharge",
                    {ba2, a2}, {cur_addr[19], 3'b100, cur_addr[7:0]});
                chk((c == 4'b0100) == cur_we, "R4 direction", c, cur_we ? 4'b0100 : 4'b0101);
                if (c == 4'b0100) begin
                    chk(oe2 && dqo2 == cur_data, "R5 write data", {oe2, dqo2}, {1'b1, cur_data});
                    chk(m2 == ~cur_be, "R5 write mask", m2, ~cur_be);
                end else begin
                    chk(!oe2, "R5 oe low on READ", oe2, 0);
                    rd_cmd_cyc = cyc;
                end
                rw_count++;
            end
            if (c == 4'b0001 && n_cmds >= 4) begin
                if (n_pref > 0) chk(cyc - last_pref <= REF_CYC + 16, "R7 refresh gap",
                                    cyc - last_pref, REF_CYC + 16);
                last_pref = cyc;
                n_pref++;
            end
            if (c != 4'b0100 && c != 4'b0001) chk(!oe2, "R5 oe low outside WRITE", oe2, 0);
            last_c = c;
            last_cyc = cyc;
            n_cmds++;
        end
        prev_cke = cke2;
    end

    task automatic access(input logic we, input logic [19:0] a, input logic [15:0] d,
                          input logic [1:0] be);
        int seen;
        logic [15:0] exp;
        @(negedge clk);
        cur_we = we; cur_addr = a; cur_data = d; cur_be = be;
        req = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        seen = rw_count;
        do @(negedge clk); while (!ack2);
        req = 0;
        while (rw_count == seen) @(negedge clk);
        if (we) begin
            ref_mem[int'(a)] = merge(ref_word(int'(a)), d, be);
        end else begin
            exp = ref_word(int'(a));
            while (!rv2) @(negedge clk);
            chk(cyc - rd_cmd_cyc == 3, "R6 CL2 capture slot", cyc - rd_cmd_cyc, 3);
            chk(rd2 == exp, "R6 CL2 read data", rd2, exp);
            while (!rv3) @(negedge clk);
            chk(cyc - rd_cmd_cyc == 4, "R6 CL3 capture slot", cyc - rd_cmd_cyc, 4);
            chk(rd3 == exp, "R6 CL3 read data", rd3, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        logic [19:0] pool [16];
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!cke2 && cs2 && !ack2 && !rv2, "R1 reset outputs CL2", {cke2, cs2, ack2, rv2}, 4'b0100);
        chk(!cke3 && cs3 && !ack3 && !rv3, "R1 reset outputs CL3", {cke3, cs3, ack3, rv3}, 4'b0100);
        rst_n = 1;
        rel_cyc = cyc;
        // request held from the start: must wait for boot (R2)
        access(1'b1, 20'h00000, 16'hA5C3, 2'b11);
        access(1'b0, 20'h00000, 16'h0, 2'b00);
        // highest bank/row/column, lower lane only
        access(1'b1, 20'hFFFFF, 16'h1234, 2'b01);
        access(1'b0, 20'hFFFFF, 16'h0, 2'b00);
        // upper lane only, then fully masked write must change nothing (R5)
        access(1'b1, 20'h4_2A_17, 16'hBEEF, 2'b10);
        access(1'b1, 20'h4_2A_17, 16'h0000, 2'b00);
        access(1'b0, 20'h4_2A_17, 16'h0, 2'b00);
        // same bank, different rows back to back
        access(1'b0, 20'h0_01_05, 16'h0, 2'b00);
        access(1'b0, 20'h0_7F_05, 16'h0, 2'b00);
        // random traffic, back to back: refresh must interleave (R7, R8)
        for (int i = 0; i < 16; i++) pool[i] = 20'($urandom);
        for (int i = 0; i < 120; i++) begin
            access(1'($urandom), pool[$urandom % 16], 16'($urandom), 2'($urandom));
        end
        repeat (200) @(negedge clk);
        chk(n_pref >= 10, "R8 refreshes under saturation", n_pref, 10);
        chk(cke2 && cke3, "R9 cke stays high", {cke2, cke3}, 2'b11);
        finish_run();
    end

endmodule